// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps a single-rank SDR SDRAM refreshed while the main command sequencer does the rest of the work. A free-running interval counter marks one owed auto-refresh each time its period runs out. Owed refreshes build up in a small backlog. The block asks the main sequencer for the command bus with a request and waits for a grant. Once granted, it closes every open bank with a precharge-all. After the row-precharge wait it issues the auto-refresh command, then stays busy for the refresh cycle time before it hands the bus back.

A power-management input asks for self-refresh. With the bus granted, the block runs the same precharge-all and wait. It then issues the refresh pin pattern with the clock enable falling, and keeps the clock enable low for as long as the request stays high. When the request drops, the block raises the clock enable with a NOP and waits out the exit recovery time before it goes idle. The interval counter is held at zero for the whole self-refresh episode.

Back-pressure works as follows. The block raises `rf_req` whenever it owes a refresh, is asked for self-refresh, or is busy. It starts a sequence only in a cycle where `rf_gnt` is sampled high. It then owns the bus until `busy` falls, and the main sequencer must keep `rf_gnt` high for that whole time. In every cycle where it issues no command of its own, it drives a NOP.

Top module: `refresh_sched`

## Requirements
- R1: During and after reset, and in every cycle where `busy` is low, the pins read cke=1, cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0 (a NOP), with `rf_req`=0 until a refresh is owed and `backlog_err`=0.
- R2: The first refresh is owed at the REFI_CLKS-th rising edge after reset release, and another every REFI_CLKS edges after that. `rf_req` is high whenever a refresh is owed, `sr_req` is high, or `busy` is high.
- R3: A sequence starts only at an edge where `rf_gnt` is high. While `rf_gnt` stays low, the pins stay at NOP and `busy` stays 0.
- R4: A granted refresh drives precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1) in the cycle after the grant is sampled. TRP_CLKS cycles later it drives auto-refresh (cke=1, cs_n=0, ras_n=0, cas_n=0, we_n=1, a10=0). The cycles between the two are NOPs.
- R5: After the auto-refresh cycle, `busy` stays high with NOP pins for TRRC_CLKS cycles and then falls. The next precharge-all comes no earlier than the cycle after that.
- R6: The backlog counts owed refreshes up to BACKLOG_MAX. When a new refresh comes due with the backlog already full, `backlog_err` goes high and stays high until reset, and the backlog stays at BACKLOG_MAX. Once granted, the block drains a full backlog with exactly BACKLOG_MAX back-to-back sequences.
- R7: If `sr_req` is high at a granted start, it takes priority over an owed auto-refresh. The block drives precharge-all, and TRP_CLKS cycles later the refresh pattern with cke=0. From then on it holds cke=0 with NOP pins while `sr_req` stays high. Entry clears the backlog.
- R8: When `sr_req` falls during self-refresh, the next cycle drives cke=1 with NOP pins. `busy` then stays high for TXSR_CLKS more cycles and falls.
- R9: The interval counter is held at zero from self-refresh entry to the end of the exit wait. The next refresh comes due REFI_CLKS edges after the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rf_gnt | input | 1 | Bus grant from the main sequencer |
| sr_req | input | 1 | Self-refresh request from power management |
| rf_req | output | 1 | Bus request to the main sequencer |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | SDRAM chip select, active low |
| ras_n | output | 1 | SDRAM row strobe, active low |
| cas_n | output | 1 | SDRAM column strobe, active low |
| we_n | output | 1 | SDRAM write enable, active low |
| a10 | output | 1 | Address bit 10, selects all banks on precharge |
| busy | output | 1 | Block owns the command bus |
| backlog_err | output | 1 | Sticky backlog overflow flag |

## Verification
The assertions assume that the grant, once given, stays high until `busy` falls. They also assume that `sr_req` changes only away from the clock edge, so that the precharge-all is always preceded by a sampled grant and self-refresh exit follows a sampled drop of `sr_req`. The stimulus drives both inputs only on falling edges. It never withdraws the grant during a sequence: it raises the grant and self-refresh request together from idle, and lowers `sr_req` only while the block sits in self-refresh. Expected pin patterns are derived cycle by cycle from the interval, the waits and the edge on which each input changed.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_TRP,
    ST_AREF,
    ST_TRRC,
    ST_SRE,
    ST_SELF,
    ST_SRX,
    ST_TXSR
  } rs_state_t;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } rs_pins_t;

  localparam rs_pins_t PINS_NOP    = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
  localparam rs_pins_t PINS_PREALL = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
  localparam rs_pins_t PINS_AREF   = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
  localparam rs_pins_t PINS_SRE    = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
  localparam rs_pins_t PINS_SHOLD  = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};

  function automatic logic in_self_refresh(rs_state_t s);
    return (s == ST_SRE) || (s == ST_SELF) || (s == ST_SRX) || (s == ST_TXSR);
  endfunction

endpackage

// File: rtl/refsched_interval.sv
module refsched_interval
  import refsched_pkg::*;
#(
  parameter int unsigned REFI_CLKS   = 1040,
  parameter int unsigned BACKLOG_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic clear,
  input  logic consume,
  output logic owed,
  output logic overflow
);

  localparam int unsigned CW = (REFI_CLKS > 1) ? $clog2(REFI_CLKS) : 1;
  localparam int unsigned BW = $clog2(BACKLOG_MAX + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(REFI_CLKS - 1);
  localparam logic [BW-1:0] BL_FULL  = BW'(BACKLOG_MAX);

  logic [CW-1:0] cnt_q;
  logic [BW-1:0] pend_q;
  logic          err_q;
  logic          tick;

  assign tick = !hold && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hold || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (clear) begin
      pend_q <= '0;
    end else begin
      unique case ({tick, consume})
        2'b10: if (pend_q != BL_FULL) pend_q <= pend_q + 1'b1;
        2'b01: if (pend_q != '0)      pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (tick && !consume && (pend_q == BL_FULL)) begin
      err_q <= 1'b1;
    end
  end

  assign owed     = (pend_q != '0);
  assign overflow = err_q;

  a_r6_backlog_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= BL_FULL);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  a_r6_consume_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> (pend_q != '0));

endmodule

// File: rtl/refsched_seq.sv
module refsched_seq
  import refsched_pkg::*;
#(
  parameter int unsigned TRP_CLKS  = 3,
  parameter int unsigned TRRC_CLKS = 9,
  parameter int unsigned TXSR_CLKS = 9
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      gnt,
  input  logic      sr_req,
  input  logic      owed,
  output rs_state_t state
);

  localparam int unsigned TMAX12 = (TRP_CLKS > TRRC_CLKS) ? TRP_CLKS : TRRC_CLKS;
  localparam int unsigned TMAX   = (TMAX12 > TXSR_CLKS) ? TMAX12 : TXSR_CLKS;
  localparam int unsigned TW     = $clog2(TMAX + 1);
  localparam logic [TW-1:0] TRP_LOAD  = TW'((TRP_CLKS >= 2) ? TRP_CLKS - 2 : 0);
  localparam logic [TW-1:0] TRRC_LOAD = TW'((TRRC_CLKS >= 1) ? TRRC_CLKS - 1 : 0);
  localparam logic [TW-1:0] TXSR_LOAD = TW'((TXSR_CLKS >= 1) ? TXSR_CLKS - 1 : 0);

  rs_state_t     st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          sr_mode_q, sr_mode_d;
  rs_state_t     after_wait;

  assign after_wait = sr_mode_q ? ST_SRE : ST_AREF;

  always_comb begin
    st_d      = st_q;
    tmr_d     = (tmr_q != '0) ? tmr_q - 1'b1 : tmr_q;
    sr_mode_d = sr_mode_q;
    unique case (st_q)
      ST_IDLE: begin
        if (gnt && sr_req) begin
          st_d      = ST_PRE;
          sr_mode_d = 1'b1;
        end else if (gnt && owed) begin
          st_d      = ST_PRE;
          sr_mode_d = 1'b0;
        end
      end
      ST_PRE: begin
        if (TRP_CLKS >= 2) begin
          st_d  = ST_TRP;
          tmr_d = TRP_LOAD;
        end else begin
          st_d = after_wait;
        end
      end
      ST_TRP:  if (tmr_q == '0) st_d = after_wait;
      ST_AREF: begin
        st_d  = ST_TRRC;
        tmr_d = TRRC_LOAD;
      end
      ST_TRRC: if (tmr_q == '0) st_d = ST_IDLE;
      ST_SRE:  st_d = ST_SELF;
      ST_SELF: if (!sr_req) st_d = ST_SRX;
      ST_SRX: begin
        st_d  = ST_TXSR;
        tmr_d = TXSR_LOAD;
      end
      ST_TXSR: if (tmr_q == '0) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      tmr_q     <= '0;
      sr_mode_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      tmr_q     <= tmr_d;
      sr_mode_q <= sr_mode_d;
    end
  end

  assign state = st_q;

  a_r3_grant_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PRE) |-> $past(gnt));

  a_r4_refresh_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AREF) |-> ($past(st_q) == ST_TRP || $past(st_q) == ST_PRE));

  a_r8_exit_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SRX) |-> ($past(st_q) == ST_SELF && !$past(sr_req)));

  a_r5_recover_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && $past(st_q) != ST_IDLE) |->
      ($past(st_q) == ST_TRRC || $past(st_q) == ST_TXSR));

endmodule

// File: rtl/refsched_cmd_enc.sv
module refsched_cmd_enc
  import refsched_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rs_state_t state,
  output rs_pins_t  pins,
  output logic      busy
);

  always_comb begin
    unique case (state)
      ST_PRE:  pins = PINS_PREALL;
      ST_AREF: pins = PINS_AREF;
      ST_SRE:  pins = PINS_SRE;
      ST_SELF: pins = PINS_SHOLD;
      default: pins = PINS_NOP;
    endcase
  end

  assign busy = (state != ST_IDLE);

  a_r1_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pins == PINS_NOP));

  a_r7_cke_fall_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pins.cke) |-> (!pins.cs_n && !pins.ras_n && !pins.cas_n && pins.we_n));

  a_r8_cke_rise_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins.cke) |-> (pins == PINS_NOP && busy));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int unsigned REFI_CLKS   = 1040,
  parameter int unsigned TRP_CLKS    = 3,
  parameter int unsigned TRRC_CLKS   = 9,
  parameter int unsigned TXSR_CLKS   = 9,
  parameter int unsigned BACKLOG_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rf_gnt,
  input  logic sr_req,
  output logic rf_req,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic a10,
  output logic busy,
  output logic backlog_err
);

  rs_state_t state;
  rs_pins_t  pins;
  logic      owed;
  logic      busy_w;

  refsched_interval #(
    .REFI_CLKS  (REFI_CLKS),
    .BACKLOG_MAX(BACKLOG_MAX)
  ) u_interval (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (in_self_refresh(state)),
    .clear   (state == ST_SRE),
    .consume (state == ST_AREF),
    .owed    (owed),
    .overflow(backlog_err)
  );

  refsched_seq #(
    .TRP_CLKS (TRP_CLKS),
    .TRRC_CLKS(TRRC_CLKS),
    .TXSR_CLKS(TXSR_CLKS)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .gnt   (rf_gnt),
    .sr_req(sr_req),
    .owed  (owed),
    .state (state)
  );

  refsched_cmd_enc u_enc (
    .clk  (clk),
    .rst_n(rst_n),
    .state(state),
    .pins (pins),
    .busy (busy_w)
  );

  assign cke    = pins.cke;
  assign cs_n   = pins.cs_n;
  assign ras_n  = pins.ras_n;
  assign cas_n  = pins.cas_n;
  assign we_n   = pins.we_n;
  assign a10    = pins.a10;
  assign busy   = busy_w;
  assign rf_req = busy_w || owed || sr_req;

  a_r2_req_covers_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rf_req);

endmodule

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;

  localparam int REFI = 24;
  localparam int TRP  = 3;
  localparam int TRRC = 9;
  localparam int TXSR = 9;
  localparam int BMAX = 4;

  localparam logic [5:0] P_NOP  = 6'b101110;
  localparam logic [5:0] P_PRE  = 6'b100101;
  localparam logic [5:0] P_REF  = 6'b100010;
  localparam logic [5:0] P_SRE  = 6'b000010;
  localparam logic [5:0] P_SELF = 6'b001110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rf_gnt = 1'b0;
  logic sr_req = 1'b0;
  logic rf_req, cke, cs_n, ras_n, cas_n, we_n, a10, busy, backlog_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refresh_sched #(
    .REFI_CLKS  (REFI),
    .TRP_CLKS   (TRP),
    .TRRC_CLKS  (TRRC),
    .TXSR_CLKS  (TXSR),
    .BACKLOG_MAX(BMAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .rf_gnt(rf_gnt), .sr_req(sr_req), .rf_req(rf_req),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10),
    .busy(busy), .backlog_err(backlog_err)
  );

  function automatic logic [8:0] observed();
    return {cke, cs_n, ras_n, cas_n, we_n, a10, busy, rf_req, backlog_err};
  endfunction

  // Expected {pins, busy, req, err} with grant always high, k edges after reset.
  function automatic logic [8:0] exp_granted(int k);
    int o;
    if (k < REFI) return {P_NOP, 3'b000};
    o = k % REFI;
    if (o == 0)               return {P_NOP, 3'b010};
    if (o == 1)               return {P_PRE, 3'b110};
    if (o <= TRP)             return {P_NOP, 3'b110};
    if (o == TRP + 1)         return {P_REF, 3'b110};
    if (o <= TRP + 1 + TRRC)  return {P_NOP, 3'b110};
    return {P_NOP, 3'b000};
  endfunction

  task automatic chk(string tag, int k, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d got %b expected %b", tag, k, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    rf_gnt = 1'b0;
    sr_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", 0, observed(), {P_NOP, 3'b000});
    rst_n = 1'b1;
  endtask

  initial begin
    int refs;
    // Test 1: grant held high, periodic refresh sequences (R2 R3 R4 R5).
    do_reset();
    rf_gnt = 1'b1;
    for (int k = 1; k <= 5 * REFI; k++) begin
      @(negedge clk);
      chk("R2 R4 R5 periodic refresh", k, observed(), exp_granted(k));
    end

    // Test 2: grant withheld, backlog overflow, then drain (R3 R6).
    do_reset();
    for (int k = 1; k <= (BMAX + 1) * REFI + 2; k++) begin
      @(negedge clk);
      chk("R3 R6 grant withheld", k, observed(),
          {P_NOP, 1'b0, (k >= REFI), (k >= (BMAX + 1) * REFI)});
    end
    rf_gnt = 1'b1;
    refs = 0;
    for (int k = (BMAX + 1) * REFI + 3; k <= (BMAX + 1) * REFI + 2 + 14 * BMAX; k++) begin
      @(negedge clk);
      if ({cke, cs_n, ras_n, cas_n, we_n, a10} == P_REF) refs++;
      chk("R6 error stays set", k, {8'h00, backlog_err}, 9'd1);
    end
    chk("R6 drained refresh count", 0, 9'(refs), 9'(BMAX));

    // Test 3: self-refresh entry with backlog, hold, exit, counter restart (R7 R8 R9).
    do_reset();
    begin
      int k0, k1, base;
      k0   = 2 * REFI + 2;
      k1   = k0 + TRP + 1 + 3 * REFI;
      base = k1 + TXSR + 1;
      for (int k = 1; k <= base + REFI + TRP + 2; k++) begin
        logic [8:0] e;
        @(negedge clk);
        if (k < REFI)             e = {P_NOP, 3'b000};
        else if (k < k0)          e = {P_NOP, 3'b010};
        else if (k == k0)         e = {P_PRE, 3'b110};
        else if (k < k0 + TRP)    e = {P_NOP, 3'b110};
        else if (k == k0 + TRP)   e = {P_SRE, 3'b110};
        else if (k < k1)          e = {P_SELF, 3'b110};
        else if (k < base)        e = {P_NOP, 3'b110};
        else                      e = exp_granted(k - base);
        if (k < k1)        chk("R7 self-refresh entry and hold", k, observed(), e);
        else if (k < base) chk("R8 self-refresh exit", k, observed(), e);
        else               chk("R9 counter restart after exit", k, observed(), e);
        if (k == k0 - 1) begin
          sr_req = 1'b1;
          rf_gnt = 1'b1;
        end
        if (k == k1 - 1) sr_req = 1'b0;
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule